// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a small 8-bit accumulator machine. On each enabled clock edge it takes an operation code, the accumulator, a memory operand and the six condition flags. It registers a result byte and the updated flags. It covers two add forms, a bitwise AND, left and right arithmetic shifts, and clearing one chosen bit of the memory operand.

Beside the byte path there is a 16-bit path. It adds a signed 8-bit immediate, taken from the memory operand input, to a 16-bit pointer. Two operation codes select this path, one for the stack pointer and one for the index pair. The core also evaluates three conditional branches and forms their target from the program counter. Instruction fetch, operand addressing and bus timing belong to the surrounding sequencer. The flag vector is packed as {V,H,I,N,Z,C}: V is bit 5, H bit 4, I bit 3, N bit 2, Z bit 1 and C bit 0.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, every registered output reads zero.
- R2: With en high, op 0 (add) registers acc_in+mem_in and op 1 (add with carry) registers acc_in+mem_in+C. Flag C takes the carry out of bit 7 in both forms.
- R3: For ops 0 and 1, flag H is the carry out of bit 3, counting the carry-in for op 1.
- R4: For ops 0 and 1, flag V is set exactly when both addends have the same sign and the result sign differs from it.
- R5: Op 2 registers acc_in AND mem_in and clears V. It keeps H, I and C from ccr_in.
- R6: Ops 3 and 4 (two names for the same left shift) give identical outputs. Both register acc_in shifted left with 0 entering bit 0, set C to the old bit 7 and keep H and I.
- R7: Op 5 registers acc_in shifted right with bit 7 kept and C set to the old bit 0. For ops 3, 4 and 5, V equals N XOR C after the shift.
- R8: For ops 0 to 5, N is result bit 7 and Z is set exactly when the result byte is zero. No op changes flag I.
- R9: Op 6 (stack pointer) and op 7 (index pair) register ptr_out = ptr_in + sign-extended mem_in, wrapping at 16 bits. They copy ccr_in to ccr_out unchanged and register res_out = acc_in. On any other op, ptr_out holds its value.
- R10: On every enabled op, br_target becomes pc_in + 2 + sign-extended mem_in. br_taken is set when op 9 runs with C=0, when op 10 runs with C=1, or when op 11 runs with Z=1. Every other op clears it.
- R11: Op 8 registers mem_in with bit bit_sel forced to 0 and copies the flags unchanged.
- R12: While en is low, all outputs hold. Ops 12 to 15 register res_out = acc_in with the flags unchanged and br_taken low, and leave ptr_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute op on this edge |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand, pointer immediate or branch offset |
| ccr_in | input | 6 | Current flags {V,H,I,N,Z,C} |
| bit_sel | input | 3 | Bit index for the clear-bit op |
| ptr_in | input | 16 | Pointer to adjust |
| pc_in | input | 16 | Program counter for branch target |
| res_out | output | 8 | Registered result byte |
| ccr_out | output | 6 | Registered flags {V,H,I,N,Z,C} |
| ptr_out | output | 16 | Registered adjusted pointer |
| br_taken | output | 1 | Registered branch decision |
| br_target | output | 16 | Registered branch target |

## Verification
The properties assume that en and op are never unknown once reset is released. They also assume that the operands sampled with an enabled op are the ones that op's result depends on, because each check compares the output one edge later with the inputs seen at the enabling edge. The stimulus keeps within this: it changes inputs only on falling edges, it raises en for exactly one edge per operation, and it drives every input to a defined value from time zero. It reaches the carry, sign and zero corner cases with chosen operand pairs.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int OW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [OW-1:0]         op,
  input  logic [DW-1:0]         acc_in,
  input  logic [DW-1:0]         mem_in,
  input  logic [5:0]            ccr_in,
  input  logic [$clog2(DW)-1:0] bit_sel,
  input  logic [AW-1:0]         ptr_in,
  input  logic [AW-1:0]         pc_in,
  output logic [DW-1:0]         res_out,
  output logic [5:0]            ccr_out,
  output logic [AW-1:0]         ptr_out,
  output logic                  br_taken,
  output logic [AW-1:0]         br_target
);
  localparam int HB = DW / 2;
  localparam int FV = 5, FH = 4, FN = 2, FZ = 1, FC = 0;
  localparam logic [OW-1:0] OP_ADD = OW'(0), OP_ADC = OW'(1), OP_AND = OW'(2),
                            OP_ASL = OW'(3), OP_LSL = OW'(4), OP_ASR = OW'(5),
                            OP_SPA = OW'(6), OP_HXA = OW'(7), OP_BCLR = OW'(8),
                            OP_BCC = OW'(9), OP_BCS = OW'(10), OP_BEQ = OW'(11);

  logic          cin;
  logic [DW:0]   sum;
  logic [AW-1:0] rel;
  logic [DW-1:0] n_res;
  logic [5:0]    n_ccr;
  logic          n_tk;
  logic          is_shift;

  assign cin      = (op == OP_ADC) & ccr_in[FC];
  assign sum      = {1'b0, acc_in} + {1'b0, mem_in} + {{DW{1'b0}}, cin};
  assign rel      = {{(AW-DW){mem_in[DW-1]}}, mem_in};
  assign is_shift = (op == OP_ASL) || (op == OP_LSL) || (op == OP_ASR);

  always_comb begin
    n_res = acc_in;
    n_ccr = ccr_in;
    n_tk  = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        n_res     = sum[DW-1:0];
        n_ccr[FV] = (acc_in[DW-1] == mem_in[DW-1]) && (sum[DW-1] != acc_in[DW-1]);
        n_ccr[FH] = acc_in[HB] ^ mem_in[HB] ^ sum[HB];
        n_ccr[FC] = sum[DW];
      end
      OP_AND: begin
        n_res     = acc_in & mem_in;
        n_ccr[FV] = 1'b0;
      end
      OP_ASL, OP_LSL: begin
        n_res     = {acc_in[DW-2:0], 1'b0};
        n_ccr[FC] = acc_in[DW-1];
      end
      OP_ASR: begin
        n_res     = {acc_in[DW-1], acc_in[DW-1:1]};
        n_ccr[FC] = acc_in[0];
      end
      OP_BCLR: n_res = mem_in & ~({{(DW-1){1'b0}}, 1'b1} << bit_sel);
      OP_BCC:  n_tk  = ~ccr_in[FC];
      OP_BCS:  n_tk  = ccr_in[FC];
      OP_BEQ:  n_tk  = ccr_in[FZ];
      default: ;
    endcase
    if (op <= OP_ASR) begin
      n_ccr[FN] = n_res[DW-1];
      n_ccr[FZ] = (n_res == '0);
    end
    if (is_shift) n_ccr[FV] = n_ccr[FN] ^ n_ccr[FC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out   <= '0;
      ccr_out   <= '0;
      ptr_out   <= '0;
      br_taken  <= 1'b0;
      br_target <= '0;
    end else if (en) begin
      res_out   <= n_res;
      ccr_out   <= n_ccr;
      br_taken  <= n_tk;
      br_target <= pc_in + AW'(2) + rel;
      if (op == OP_SPA || op == OP_HXA) ptr_out <= ptr_in + rel;
    end
  end
endmodule

module acc_alu_chk #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int OW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [OW-1:0]         op,
  input logic [DW-1:0]         acc_in,
  input logic [DW-1:0]         mem_in,
  input logic [5:0]            ccr_in,
  input logic [$clog2(DW)-1:0] bit_sel,
  input logic [AW-1:0]         ptr_in,
  input logic [DW-1:0]         res_out,
  input logic [5:0]            ccr_out,
  input logic [AW-1:0]         ptr_out,
  input logic                  br_taken
);
  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OW'(2)) |=> (!ccr_out[5] && ccr_out[4] == $past(ccr_in[4]) && ccr_out[0] == $past(ccr_in[0]))); // R5
  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OW'(3) || op == OW'(4) || op == OW'(5))) |=> (ccr_out[5] == (ccr_out[2] ^ ccr_out[0]))); // R7
  AST_ASR_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OW'(5)) |=> (res_out[DW-1] == $past(acc_in[DW-1]) && ccr_out[0] == $past(acc_in[0]))); // R7
  AST_NZ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= OW'(5)) |=> (ccr_out[1] == (res_out == '0) && ccr_out[2] == res_out[DW-1])); // R8
  AST_I_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ccr_out[3] == $past(ccr_in[3]))); // R8
  AST_PTR_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OW'(6) || op == OW'(7))) |=>
      (ccr_out == $past(ccr_in) && ptr_out == $past(ptr_in) + {{(AW-DW){$past(mem_in[DW-1])}}, $past(mem_in)})); // R9
  AST_BCLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OW'(8)) |=> (res_out[$past(bit_sel)] == 1'b0 && ccr_out == $past(ccr_in))); // R11
  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op < OW'(9) || op > OW'(11))) |=> !br_taken); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_out) && $stable(ccr_out) && $stable(ptr_out) && $stable(br_taken))); // R12
endmodule

bind acc_alu acc_alu_chk #(.DW(DW), .AW(AW), .OW(OW)) u_chk (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  acc_in = '0, mem_in = '0;
  logic [5:0]  ccr_in = '0;
  logic [2:0]  bit_sel = '0;
  logic [15:0] ptr_in = '0, pc_in = '0;
  logic [7:0]  res_out;
  logic [5:0]  ccr_out;
  logic [15:0] ptr_out, br_target;
  logic        br_taken;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (.clk, .rst_n, .en, .op, .acc_in, .mem_in, .ccr_in, .bit_sel,
                     .ptr_in, .pc_in, .res_out, .ccr_out, .ptr_out, .br_taken, .br_target);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] m,
                     input logic [5:0] c);
    @(negedge clk);
    op = o; acc_in = a; mem_in = m; ccr_in = c; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 res", res_out, 0);
    chk("R1 ccr", ccr_out, 0);
    chk("R1 ptr", ptr_out, 0);
    chk("R1 tk", br_taken, 0);
    chk("R1 tgt", br_target, 0);
  endtask

  task automatic t_add(input logic [7:0] a, input logic [7:0] m, input bit carry_in,
                       input bit use_adc, input logic [5:0] c);
    int s, hs, ss, ci;
    logic v, h, cy, n, z;
    ci = (use_adc && c[0]) ? 1 : 0;
    run(use_adc ? 4'd1 : 4'd0, a, m, {c[5:1], carry_in});
    ci = (use_adc && carry_in) ? 1 : 0;
    s  = int'(a) + int'(m) + ci;
    hs = int'(a & 8'h0f) + int'(m & 8'h0f) + ci;
    ss = int'($signed(a)) + int'($signed(m)) + ci;
    v = (ss > 127) || (ss < -128);
    h = hs > 15; cy = s > 255;
    n = s[7]; z = (s & 255) == 0;
    chk("R2 sum", res_out, s & 255);
    chk("R2 carry", ccr_out[0], cy);
    chk("R3 half", ccr_out[4], h);
    chk("R4 ovf", ccr_out[5], v);
    chk("R8 nz", {ccr_out[3], ccr_out[2], ccr_out[1]}, {c[3], n, z});
  endtask

  task automatic t_and(input logic [7:0] a, input logic [7:0] m, input logic [5:0] c);
    logic [7:0] r;
    run(4'd2, a, m, c);
    r = a & m;
    chk("R5 and", res_out, r);
    chk("R5 flags", ccr_out, {1'b0, c[4], c[3], r[7], r == 0, c[0]});
  endtask

  task automatic t_shl(input logic [7:0] a, input logic [5:0] c);
    logic [7:0] r; logic [5:0] e; logic [7:0] r3; logic [5:0] c3;
    r = a << 1;
    e = {r[7] ^ a[7], c[4], c[3], r[7], r == 0, a[7]};
    run(4'd3, a, 8'h00, c);
    r3 = res_out; c3 = ccr_out;
    chk("R6 asl res", r3, r);
    chk("R6 asl ccr", c3, e);
    run(4'd4, a, 8'h00, c);
    chk("R6 lsl same", {res_out, ccr_out}, {r3, c3});
  endtask

  task automatic t_asr(input logic [7:0] a, input logic [5:0] c);
    logic [7:0] r;
    r = {a[7], a[7:1]};
    run(4'd5, a, 8'h00, c);
    chk("R7 asr res", res_out, r);
    chk("R7 asr ccr", ccr_out, {r[7] ^ a[0], c[4], c[3], r[7], r == 0, a[0]});
  endtask

  task automatic t_ptr(input logic [3:0] o, input logic [15:0] p, input logic [7:0] imm,
                       input logic [15:0] exp_p);
    @(negedge clk); ptr_in = p;
    run(o, 8'h5a, imm, 6'b101101);
    chk("R9 ptr", ptr_out, exp_p);
    chk("R9 ccr", ccr_out, 6'b101101);
    chk("R9 res", res_out, 8'h5a);
  endtask

  task automatic t_branch(input logic [3:0] o, input logic [5:0] c, input logic [15:0] pc,
                          input logic [7:0] rel, input bit exp_tk, input logic [15:0] exp_t);
    @(negedge clk); pc_in = pc;
    run(o, 8'h00, rel, c);
    chk("R10 taken", br_taken, exp_tk);
    chk("R10 target", br_target, exp_t);
  endtask

  task automatic t_bclr(input logic [7:0] m, input logic [2:0] b, input logic [7:0] exp_r);
    @(negedge clk); bit_sel = b;
    run(4'd8, 8'h33, m, 6'b010110);
    chk("R11 bclr", res_out, exp_r);
    chk("R11 ccr", ccr_out, 6'b010110);
  endtask

  task automatic t_hold;
    logic [7:0] r; logic [5:0] c; logic [15:0] p;
    run(4'd0, 8'h12, 8'h34, 6'b000000);
    r = res_out; c = ccr_out; p = ptr_out;
    @(negedge clk);
    op = 4'd6; acc_in = 8'hff; mem_in = 8'h7f; ccr_in = 6'h3f; ptr_in = 16'h4444;
    repeat (3) @(negedge clk);
    chk("R12 hold", {res_out, ccr_out, ptr_out}, {r, c, p});
    run(4'd13, 8'hc4, 8'h11, 6'b111111);
    chk("R12 unused res", res_out, 8'hc4);
    chk("R12 unused ccr", ccr_out, 6'b111111);
    chk("R12 unused ptr", ptr_out, p);
    chk("R12 unused tk", br_taken, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_add(8'h12, 8'h34, 1'b0, 1'b0, 6'b001000);
    t_add(8'h0f, 8'h01, 1'b0, 1'b0, 6'b000000);
    t_add(8'h7f, 8'h01, 1'b0, 1'b0, 6'b000000);
    t_add(8'h80, 8'h80, 1'b0, 1'b0, 6'b001000);
    t_add(8'hff, 8'h00, 1'b1, 1'b1, 6'b000000);
    t_add(8'h0e, 8'h01, 1'b1, 1'b1, 6'b001000);
    t_add(8'hff, 8'h00, 1'b1, 1'b0, 6'b000000);
    t_and(8'hf0, 8'h0f, 6'b111111);
    t_and(8'hc3, 8'h81, 6'b100000);
    t_shl(8'h81, 6'b011000);
    t_shl(8'h40, 6'b000001);
    t_shl(8'h00, 6'b000000);
    t_asr(8'h81, 6'b010000);
    t_asr(8'h01, 6'b001000);
    t_asr(8'h7e, 6'b000001);
    t_ptr(4'd6, 16'hfff0, 8'h20, 16'h0010);
    t_ptr(4'd7, 16'h0100, 8'hf0, 16'h00f0);
    t_branch(4'd9,  6'b000000, 16'h1000, 8'hfe, 1'b1, 16'h1000);
    t_branch(4'd9,  6'b000001, 16'h1000, 8'h10, 1'b0, 16'h1012);
    t_branch(4'd10, 6'b000001, 16'h1000, 8'h80, 1'b1, 16'h0f82);
    t_branch(4'd10, 6'b000000, 16'hfffe, 8'h7f, 1'b0, 16'h007f);
    t_branch(4'd11, 6'b000010, 16'h2000, 8'h04, 1'b1, 16'h2006);
    t_branch(4'd11, 6'b000001, 16'h2000, 8'h04, 1'b0, 16'h2006);
    t_bclr(8'hff, 3'd0, 8'hfe);
    t_bclr(8'hff, 3'd7, 8'h7f);
    t_bclr(8'h10, 3'd3, 8'h10);
    t_hold;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule